// File: doc/BRIEF.md
# Threshold Comparator Peripheral

This block is a digital stand-in for the analog comparator of a small microcontroller. Input levels arrive as unsigned millivolt codes: two dedicated inputs and a bank of multiplexed channel inputs. The block picks a positive operand and a negative operand, decides whether positive is strictly above negative, and keeps the answer in a registered output bit. When that bit flips, it can set a sticky interrupt flag and send a one-cycle trigger to a timer's capture logic.

The positive side is either dedicated input 0 or a fixed 1100 mV reference. The negative side is either dedicated input 1 or one channel of the bank. The choice depends on a local mux-enable bit and on two bits that belong to the neighbouring converter: its enable bit and its power-down bit. Software reaches the block through one 8-bit control register. All level and select inputs are registered once. The output therefore follows any input change on the second rising edge, and follows a register write on the second edge after the write is accepted.

Top module: `volt_comparator`

## Requirements
- R1: After synchronous reset, `cmp_out`, `irq` and `cap_trig` are 0, and `reg_rdata` reads 8'h00.
- R2: The positive operand is 1100 when the reference bit (register bit 1) is set. Otherwise it is `ain0_mv`.
- R3: The next output value is 1 only when the positive operand is strictly greater than the negative operand. Equal values give 0.
- R4: The negative operand comes from the channel bank only when the mux-enable bit (register bit 2) is 1 and `conv_en` is 0. Otherwise it is `ain1_mv`.
- R5: In channel-bank mode, a high `conv_pwr_down` makes the negative operand 0.
- R6: In channel-bank mode, a `chan_sel` value of NCH or above makes the negative operand 0. Channel NCH-1 is still selected normally.
- R7: While the disable bit (register bit 0) is 1, `cmp_out` holds its value. No interrupt flag is set and no capture trigger is sent. Clearing the bit lets the output follow the comparison again.
- R8: A change on any level or select input shows on `cmp_out` after the second rising edge, not after the first. A register write accepted on one edge shows on `cmp_out` after the next edge.
- R9: Register bits 6:5 select the interrupt mode:
  - 00: any change of `cmp_out` sets the flag.
  - 01: the flag is never set.
  - 10: only a change to 0 sets the flag.
  - 11: only a change to 1 sets the flag.
- R10: The flag (register bit 7) stays set until a write with bit 7 = 1 clears it. `irq` is the flag ANDed with the interrupt-enable bit (register bit 4).
- R11: When the capture-enable bit (register bit 3) is 1, `cap_trig` is high for exactly one cycle, in the cycle `cmp_out` takes its new value. When that bit is 0, `cap_trig` stays low.
- R12: `reg_rdata` returns the written values of bits 6:0 and the live flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ain0_mv | input | VAL_W | Dedicated input 0, millivolts |
| ain1_mv | input | VAL_W | Dedicated input 1, millivolts |
| chan_mv | input | NCH*VAL_W | Channel bank; channel i occupies bits [i*VAL_W +: VAL_W] |
| conv_en | input | 1 | Neighbouring converter is enabled |
| conv_pwr_down | input | 1 | Neighbouring converter is powered down |
| chan_sel | input | SEL_W | Channel index for the bank |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| cmp_out | output | 1 | Registered comparison result |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | One-cycle capture trigger for a timer |

## Verification
A wrong stored output bit shows on `cmp_out` right away. It also shows within two edges of the next input change, as a missing or extra flag and capture pulse, because events come from comparing the new result with the stored bit. A wrong operand selection shows as a wrong `cmp_out` two edges after the select or level input moves. The bench places each select case at a value where the correct and incorrect operand give opposite results. A flag that sets or clears wrongly shows on `reg_rdata` bit 7 and on `irq` one edge after the event or the clearing write.

// File: rtl/vc_pkg.sv
// Shared definitions for the threshold comparator: register bit positions,
// interrupt mode encoding and the decoded configuration record.
// Assumes an 8-bit control register with the layout given in the brief.
package vc_pkg;

    localparam int VC_REG_W   = 8;
    localparam int VC_B_DIS   = 0;
    localparam int VC_B_REF   = 1;
    localparam int VC_B_MUXEN = 2;
    localparam int VC_B_CAPEN = 3;
    localparam int VC_B_IRQEN = 4;
    localparam int VC_B_MODE  = 5;   // two bits, 6:5
    localparam int VC_B_FLAG  = 7;

    typedef enum logic [1:0] {
        VC_EV_ANY  = 2'b00,
        VC_EV_NONE = 2'b01,
        VC_EV_FALL = 2'b10,
        VC_EV_RISE = 2'b11
    } vc_mode_e;

    typedef struct packed {
        logic     dis;
        logic     ref_sel;
        logic     mux_en;
        logic     cap_en;
        logic     irq_en;
        vc_mode_e mode;
    } vc_cfg_t;

endpackage

// File: rtl/vc_input_stage.sv
// Input register stage: samples all level codes and selection controls once
// per clock so the comparison works on a stable, registered snapshot.
// Assumes inputs are synchronous to clk.
module vc_input_stage #(
    parameter int VAL_W = 16,
    parameter int NCH   = 16,
    parameter int SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VAL_W-1:0]     ain0_i,
    input  logic [VAL_W-1:0]     ain1_i,
    input  logic [NCH*VAL_W-1:0] chan_i,
    input  logic                 conv_en_i,
    input  logic                 pwr_down_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [VAL_W-1:0]     ain0_q,
    output logic [VAL_W-1:0]     ain1_q,
    output logic [NCH*VAL_W-1:0] chan_q,
    output logic                 conv_en_q,
    output logic                 pwr_down_q,
    output logic [SEL_W-1:0]     sel_q
);

    // Dedicated inputs and selection controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ain0_q     <= '0;
            ain1_q     <= '0;
            conv_en_q  <= 1'b0;
            pwr_down_q <= 1'b0;
            sel_q      <= '0;
        end else begin
            ain0_q     <= ain0_i;
            ain1_q     <= ain1_i;
            conv_en_q  <= conv_en_i;
            pwr_down_q <= pwr_down_i;
            sel_q      <= sel_i;
        end
    end

    // One register slice per channel of the bank.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) chan_q[g*VAL_W +: VAL_W] <= '0;
            else        chan_q[g*VAL_W +: VAL_W] <= chan_i[g*VAL_W +: VAL_W];
        end
    end

endmodule

// File: rtl/vc_ctrl_reg.sv
// Control register: holds the configuration bits, decodes the flag-clear
// request and assembles readback. Assumes single-cycle write strobes.
module vc_ctrl_reg
    import vc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [VC_REG_W-1:0] wdata_i,
    input  logic                flag_i,
    output vc_cfg_t             cfg_o,
    output logic                flag_clr_o,
    output logic [VC_REG_W-1:0] rdata_o
);

    // Configuration storage, updated on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '{dis: 1'b0, ref_sel: 1'b0, mux_en: 1'b0, cap_en: 1'b0,
                       irq_en: 1'b0, mode: VC_EV_ANY};
        end else if (we_i) begin
            cfg_o.dis     <= wdata_i[VC_B_DIS];
            cfg_o.ref_sel <= wdata_i[VC_B_REF];
            cfg_o.mux_en  <= wdata_i[VC_B_MUXEN];
            cfg_o.cap_en  <= wdata_i[VC_B_CAPEN];
            cfg_o.irq_en  <= wdata_i[VC_B_IRQEN];
            cfg_o.mode    <= vc_mode_e'(wdata_i[VC_B_MODE +: 2]);
        end
    end

    // Write-one-to-clear request for the flag.
    assign flag_clr_o = we_i && wdata_i[VC_B_FLAG];

    // Readback assembly in register bit order.
    always_comb begin
        rdata_o                  = '0;
        rdata_o[VC_B_DIS]        = cfg_o.dis;
        rdata_o[VC_B_REF]        = cfg_o.ref_sel;
        rdata_o[VC_B_MUXEN]      = cfg_o.mux_en;
        rdata_o[VC_B_CAPEN]      = cfg_o.cap_en;
        rdata_o[VC_B_IRQEN]      = cfg_o.irq_en;
        rdata_o[VC_B_MODE +: 2]  = cfg_o.mode;
        rdata_o[VC_B_FLAG]       = flag_i;
    end

endmodule

// File: rtl/vc_operand_sel.sv
// Operand selection: picks the positive operand (reference or input 0) and
// the negative operand (input 1 or a bank channel), zeroing the negative
// side when the converter is powered down or the index is out of range.
// Purely combinational on registered inputs.
module vc_operand_sel #(
    parameter int              VAL_W  = 16,
    parameter int              NCH    = 16,
    parameter int              SEL_W  = 4,
    parameter logic [VAL_W-1:0] REF_MV = VAL_W'(1100)
) (
    input  logic                 ref_sel_i,
    input  logic                 mux_en_i,
    input  logic                 conv_en_i,
    input  logic                 pwr_down_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [VAL_W-1:0]     ain0_i,
    input  logic [VAL_W-1:0]     ain1_i,
    input  logic [NCH*VAL_W-1:0] chan_i,
    output logic [VAL_W-1:0]     pos_o,
    output logic [VAL_W-1:0]     neg_o
);

    logic [VAL_W-1:0] ch [NCH];
    logic [VAL_W-1:0] picked;
    logic             in_range;
    logic             bank_path;

    // Unpack the flat bank into an indexed array.
    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign ch[g] = chan_i[g*VAL_W +: VAL_W];
    end

    // Channel pick by comparison, which leaves zero when nothing matches.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_i == SEL_W'(i)) picked = ch[i];
        end
    end

    assign in_range  = int'(sel_i) < NCH;
    assign bank_path = mux_en_i && !conv_en_i;

    // Final operand choice.
    always_comb begin
        pos_o = ref_sel_i ? REF_MV : ain0_i;
        if (!bank_path)                  neg_o = ain1_i;
        else if (pwr_down_i || !in_range) neg_o = '0;
        else                             neg_o = picked;
    end

endmodule

// File: rtl/vc_event_gen.sv
// Result and event logic: compares operands, keeps the output bit, raises
// the sticky flag by mode and issues the one-cycle capture trigger.
// Assumes the flag clear and a new event can meet; the new event wins.
module vc_event_gen
    import vc_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vc_cfg_t          cfg_i,
    input  logic [VAL_W-1:0] pos_i,
    input  logic [VAL_W-1:0] neg_i,
    input  logic             flag_clr_i,
    output logic             out_q,
    output logic             flag_q,
    output logic             cap_q
);

    logic res;
    logic change;
    logic fire;

    // Next result and whether it differs from the stored bit.
    assign res    = !cfg_i.dis && (pos_i > neg_i);
    assign change = !cfg_i.dis && (res != out_q);

    // Mode filter for the interrupt flag.
    always_comb begin
        case (cfg_i.mode)
            VC_EV_ANY:  fire = change;
            VC_EV_FALL: fire = change && !res;
            VC_EV_RISE: fire = change && res;
            default:    fire = 1'b0;
        endcase
    end

    // Output bit, flag and capture trigger registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            flag_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            if (change) out_q <= res;
            if (fire)            flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
            cap_q <= change && cfg_i.cap_en;
        end
    end

endmodule

// File: rtl/volt_comparator.sv
// Threshold comparator top: input registers, control register, operand
// selection and event generation. Inputs are synchronous to clk; reset is
// synchronous and active low.
module volt_comparator
    import vc_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int NCH    = 16,
    parameter int SEL_W  = 4,
    parameter int REF_MV = 1100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VAL_W-1:0]     ain0_mv,
    input  logic [VAL_W-1:0]     ain1_mv,
    input  logic [NCH*VAL_W-1:0] chan_mv,
    input  logic                 conv_en,
    input  logic                 conv_pwr_down,
    input  logic [SEL_W-1:0]     chan_sel,
    input  logic                 reg_we,
    input  logic [VC_REG_W-1:0]  reg_wdata,
    output logic [VC_REG_W-1:0]  reg_rdata,
    output logic                 cmp_out,
    output logic                 irq,
    output logic                 cap_trig
);

    localparam logic [VAL_W-1:0] REF_CODE = VAL_W'(REF_MV);

    logic [VAL_W-1:0]     ain0_q, ain1_q, pos, neg;
    logic [NCH*VAL_W-1:0] chan_q;
    logic                 conv_en_q, pwr_down_q, flag, flag_clr;
    logic [SEL_W-1:0]     sel_q;
    vc_cfg_t              cfg;

    vc_input_stage #(.VAL_W(VAL_W), .NCH(NCH), .SEL_W(SEL_W)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .ain0_i     (ain0_mv),
        .ain1_i     (ain1_mv),
        .chan_i     (chan_mv),
        .conv_en_i  (conv_en),
        .pwr_down_i (conv_pwr_down),
        .sel_i      (chan_sel),
        .ain0_q     (ain0_q),
        .ain1_q     (ain1_q),
        .chan_q     (chan_q),
        .conv_en_q  (conv_en_q),
        .pwr_down_q (pwr_down_q),
        .sel_q      (sel_q)
    );

    vc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .wdata_i    (reg_wdata),
        .flag_i     (flag),
        .cfg_o      (cfg),
        .flag_clr_o (flag_clr),
        .rdata_o    (reg_rdata)
    );

    vc_operand_sel #(.VAL_W(VAL_W), .NCH(NCH), .SEL_W(SEL_W), .REF_MV(REF_CODE)) u_sel (
        .ref_sel_i  (cfg.ref_sel),
        .mux_en_i   (cfg.mux_en),
        .conv_en_i  (conv_en_q),
        .pwr_down_i (pwr_down_q),
        .sel_i      (sel_q),
        .ain0_i     (ain0_q),
        .ain1_i     (ain1_q),
        .chan_i     (chan_q),
        .pos_o      (pos),
        .neg_o      (neg)
    );

    vc_event_gen #(.VAL_W(VAL_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .pos_i      (pos),
        .neg_i      (neg),
        .flag_clr_i (flag_clr),
        .out_q      (cmp_out),
        .flag_q     (flag),
        .cap_q      (cap_trig)
    );

    // Interrupt request gated by the enable bit.
    assign irq = flag && cfg.irq_en;

endmodule

// File: rtl/volt_comparator_chk.sv
// Port-level property checker for the threshold comparator, bound to the top.
module volt_comparator_chk
    import vc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [VC_REG_W-1:0] reg_wdata,
    input logic [VC_REG_W-1:0] reg_rdata,
    input logic                cmp_out,
    input logic                cap_trig
);

    a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[VC_B_DIS] |=> $stable(cmp_out));

    a_r11_cap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        cap_trig |-> (cmp_out != $past(cmp_out)));

    a_r11_cap_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cap_trig |-> $past(reg_rdata[VC_B_CAPEN]));

    a_r9_never_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[VC_B_FLAG]) |-> ($past(reg_rdata[VC_B_MODE +: 2]) != 2'b01));

    a_r9_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[VC_B_FLAG]) |-> (cmp_out != $past(cmp_out)));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[VC_B_FLAG] && !(reg_we && reg_wdata[VC_B_FLAG])) |=> reg_rdata[VC_B_FLAG]);

endmodule

bind volt_comparator volt_comparator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cmp_out   (cmp_out),
    .cap_trig  (cap_trig)
);

// File: tb/volt_comparator_tb.sv
`timescale 1ns/1ps
module volt_comparator_tb;

    localparam int VAL_W = 16;
    localparam int NCH   = 10;
    localparam int SEL_W = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [VAL_W-1:0]     ain0_mv = '0, ain1_mv = '0;
    logic [NCH*VAL_W-1:0] chan_mv = '0;
    logic                 conv_en = 1'b0, conv_pwr_down = 1'b0;
    logic [SEL_W-1:0]     chan_sel = '0;
    logic                 reg_we = 1'b0;
    logic [7:0]           reg_wdata = '0;
    logic [7:0]           reg_rdata;
    logic                 cmp_out, irq, cap_trig;

    int n_chk = 0, n_bad = 0, cap_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    volt_comparator #(.VAL_W(VAL_W), .NCH(NCH), .SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ain0_mv(ain0_mv), .ain1_mv(ain1_mv),
        .chan_mv(chan_mv), .conv_en(conv_en), .conv_pwr_down(conv_pwr_down),
        .chan_sel(chan_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_out(cmp_out), .irq(irq), .cap_trig(cap_trig)
    );

    // Capture pulses counted away from the active edge.
    always @(negedge clk) if (rst_n && cap_trig) cap_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_chan(input int i, input int v);
        chan_mv[i*VAL_W +: VAL_W] = VAL_W'(v);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out", int'(cmp_out), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 cap", int'(cap_trig), 0);
        chk("R1 rdata", int'(reg_rdata), 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_pos_ref();
        @(negedge clk); ain0_mv = 2000; ain1_mv = 1000;
        @(posedge clk); #1;
        chk("R8 one edge", int'(cmp_out), 0);
        @(posedge clk); #1;
        chk("R8 two edges / R2 ain0", int'(cmp_out), 1);
        @(negedge clk); ain0_mv = 1000;
        settle();
        chk("R3 equal", int'(cmp_out), 0);
        @(negedge clk); ain1_mv = 1099;
        settle();
        chk("R2 ain0 below", int'(cmp_out), 0);
        wr(8'h02);
        chk("R8 write one edge", int'(cmp_out), 0);
        @(posedge clk); #1;
        chk("R2 reference", int'(cmp_out), 1);
        @(negedge clk); ain1_mv = 1100;
        settle();
        chk("R3 reference equal", int'(cmp_out), 0);
        wr(8'h00);
        @(posedge clk); #1;
        chk("R10 flag sticky", int'(reg_rdata[7]), 1);
        chk("R10 irq masked", int'(irq), 0);
        wr(8'h10);
        chk("R10 irq enabled", int'(irq), 1);
        wr(8'h90);
        chk("R10 flag cleared", int'(reg_rdata[7]), 0);
        chk("R10 irq after clear", int'(irq), 0);
        wr(8'h00);
    endtask

    task automatic t_mux();
        @(negedge clk); ain0_mv = 500; set_chan(3, 400); chan_sel = 3;
        settle();
        chk("R4 mux off uses ain1", int'(cmp_out), 0);
        wr(8'h04);
        @(posedge clk); #1;
        chk("R4 channel 3 low", int'(cmp_out), 1);
        @(negedge clk); set_chan(3, 600);
        settle();
        chk("R4 channel 3 high", int'(cmp_out), 0);
        @(negedge clk); conv_en = 1'b1; ain1_mv = 100;
        settle();
        chk("R4 converter on uses ain1", int'(cmp_out), 1);
        @(negedge clk); conv_en = 1'b0;
        settle();
        chk("R4 back to channel", int'(cmp_out), 0);
        @(negedge clk); conv_pwr_down = 1'b1;
        settle();
        chk("R5 power down zero", int'(cmp_out), 1);
        @(negedge clk); conv_pwr_down = 1'b0;
        settle();
        chk("R5 power restored", int'(cmp_out), 0);
        @(negedge clk); chan_sel = 4'd10;
        settle();
        chk("R6 index NCH", int'(cmp_out), 1);
        @(negedge clk); chan_sel = 4'd3;
        settle();
        chk("R6 back in range", int'(cmp_out), 0);
        @(negedge clk); chan_sel = 4'd15;
        settle();
        chk("R6 index 15", int'(cmp_out), 1);
        @(negedge clk); set_chan(9, 600); chan_sel = 4'd9;
        settle();
        chk("R6 last channel", int'(cmp_out), 0);
        wr(8'h00);
        @(posedge clk); #1;
        chk("R4 mux off again", int'(cmp_out), 1);
    endtask

    task automatic t_disable();
        wr(8'h80);
        wr(8'h09);
        @(posedge clk); #1;
        cap_cnt = 0;
        @(negedge clk); ain0_mv = 50;
        settle();
        repeat (3) @(posedge clk);
        #1;
        chk("R7 output held", int'(cmp_out), 1);
        chk("R7 no flag", int'(reg_rdata[7]), 0);
        chk("R7 no capture", cap_cnt, 0);
        wr(8'h08);
        @(posedge clk); #1;
        chk("R7 resumes", int'(cmp_out), 0);
    endtask

    task automatic t_cap();
        @(posedge clk); #1;
        @(negedge clk); ain0_mv = 200;
        @(posedge clk);
        @(posedge clk); #1;
        chk("R11 out updated", int'(cmp_out), 1);
        chk("R11 pulse high", int'(cap_trig), 1);
        @(posedge clk); #1;
        chk("R11 pulse one cycle", int'(cap_trig), 0);
        wr(8'h00);
        @(posedge clk); #1;
        cap_cnt = 0;
        @(negedge clk); ain0_mv = 50;
        settle();
        repeat (2) @(posedge clk);
        #1;
        chk("R11 out changed", int'(cmp_out), 0);
        chk("R11 gated off", cap_cnt, 0);
    endtask

    task automatic t_mode(input logic [1:0] m, input int exp_rise, input int exp_fall);
        wr({1'b1, m, 5'b0});
        @(negedge clk); ain0_mv = 200;
        settle();
        chk($sformatf("R9 mode %0d rise", m), int'(reg_rdata[7]), exp_rise);
        wr({1'b1, m, 5'b0});
        @(negedge clk); ain0_mv = 50;
        settle();
        chk($sformatf("R9 mode %0d fall", m), int'(reg_rdata[7]), exp_fall);
    endtask

    task automatic t_layout();
        wr(8'hBE);
        #1;
        chk("R12 readback", int'(reg_rdata), 8'h3E);
    endtask

    initial begin
        t_reset();
        t_pos_ref();
        t_mux();
        t_disable();
        t_cap();
        t_mode(2'b00, 1, 1);
        t_mode(2'b01, 0, 0);
        t_mode(2'b10, 0, 1);
        t_mode(2'b11, 1, 0);
        t_layout();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule